// File: doc/BRIEF.md
# Push-Button and Enable Power-Request Controller

This block watches one shared input pin of a power-management controller and turns its activity into power requests. A static mode input chooses how the pin is read. In push-button mode the pin idles high and a press pulls it low; a press held long enough asks for power-on, and a much longer press asks for power-off. In level-enable mode the pin is a plain enable: a qualified rise asks for power-on and a qualified fall asks for power-off. A second static input picks slow or fast timing for the ON qualification.

Every timing qualification requires the synchronized pin to stay at one level for a set number of prescaler ticks. Any return to the other level restarts the count. A separate filter produces a debounced button level for an interrupt controller. A software-shutdown pulse arms a shorter qualification for the next enable fall. Requests are one-cycle pulses on plain control pins and are gated by the current power state. All durations are parameters in ticks, and `TICK_DIV` clocks make one tick.

Top module: `pwr_req_ctrl`

## Requirements
- R1: After reset, `on_req_o` and `off_req_o` are 0 and `btn_level_o` is 1 (released).
- R2: In push-button mode (`pb_mode_i`=1) while `power_on_i`=0, a low held for `PB_ON_SLOW` ticks (`fast_i`=0) or `PB_ON_FAST` ticks (`fast_i`=1) gives exactly one ON pulse, even if the press lasts longer.
- R3: In push-button mode while `power_on_i`=1, a low held for `PB_OFF_HOLD` ticks gives exactly one OFF pulse.
- R4: After a long-press OFF, the pin must be high for `PB_REL_DEGL` ticks in a row before a new press is accepted; lows seen before that restart the release count and give no request.
- R5: A return to the opposite level before a qualification count ends restarts that count and produces no request.
- R6: `btn_level_o` follows the synchronized pin only after the pin has held a new level for `PB_INT_DEGL` ticks, on both rising and falling edges, in either mode.
- R7: In enable mode (`pb_mode_i`=0) while powered off, a rise held for `EN_RISE_SLOW` ticks (slow) or `EN_RISE_FAST` ticks (fast) gives one ON pulse.
- R8: In enable mode while powered on, a fall held for `EN_FALL` ticks gives one OFF pulse, for either timing setting.
- R9: A `sw_shdn_i` pulse arms a flag. While it is armed, the next enable fall qualifies after `EN_FALL_SW` ticks. The flag is cleared when that fall is accepted or when `power_on_i` rises.
- R10: No ON pulse appears while `power_on_i` is 1, and no OFF pulse appears while it is 0. In enable mode a qualified edge that is suppressed still updates the accepted level.
- R11: Each request is high for exactly one clock, and ON and OFF are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_pin_i | input | 1 | Raw shared pin, asynchronous |
| pb_mode_i | input | 1 | Static: 1 push-button, 0 level enable |
| fast_i | input | 1 | Static: 1 fast ON timing, 0 slow |
| sw_shdn_i | input | 1 | Pulse: shutdown was requested by software |
| power_on_i | input | 1 | Current power state, 1 = on |
| on_req_o | output | 1 | One-cycle power-on request |
| off_req_o | output | 1 | One-cycle power-off request |
| btn_level_o | output | 1 | Debounced pin level for interrupts |

## Verification
A pin change reaches the timing logic two clocks later through the synchronizer. A qualification of L ticks then ends at a tick edge between (L-1)·TICK_DIV+1 and L·TICK_DIV clocks later, and the request register adds one clock. Push-button presses add one more clock for the idle-to-hold step. The debounced level has no output register, so it appears one clock earlier than a request. The scoreboard stamps each expected request with a cycle window built from these counts. The monitor rejects any pulse that is of the wrong kind, outside its window, or unexpected. The debounced level is sampled once just before its earliest possible change and once just after its latest.

// File: rtl/pr_pkg.sv
package pr_pkg;

  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_HOLD = 2'd1,
    PB_WAIT = 2'd2,
    PB_REL  = 2'd3
  } pb_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pr_sync2.sv
module pr_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pr_tick_gen.sv
module pr_tick_gen #(
  parameter int unsigned DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   pre_q <= '0;
        else if (pre_q == PW'(DIV-1))  pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
      end
      assign tick_o = (pre_q == PW'(DIV-1));
    end
  endgenerate
endmodule

// File: rtl/pr_hold_timer.sv
module pr_hold_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end   = (cnt_q >= (limit_i - 1'b1));
  assign expire_o = run_i & tick_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (tick_i)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  // R5
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_req_ctrl.sv
module pwr_req_ctrl
  import pr_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 250,
  parameter int unsigned PB_ON_SLOW   = 120000,
  parameter int unsigned PB_ON_FAST   = 40000,
  parameter int unsigned PB_OFF_HOLD  = 1600000,
  parameter int unsigned PB_REL_DEGL  = 40000,
  parameter int unsigned PB_INT_DEGL  = 20000,
  parameter int unsigned EN_RISE_SLOW = 10000,
  parameter int unsigned EN_RISE_FAST = 24,
  parameter int unsigned EN_FALL      = 14,
  parameter int unsigned EN_FALL_SW   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_pin_i,
  input  logic pb_mode_i,
  input  logic fast_i,
  input  logic sw_shdn_i,
  input  logic power_on_i,
  output logic on_req_o,
  output logic off_req_o,
  output logic btn_level_o
);
  localparam int unsigned MAX_A = umax(umax(PB_ON_SLOW, PB_ON_FAST), umax(PB_OFF_HOLD, PB_REL_DEGL));
  localparam int unsigned MAX_B = umax(umax(EN_RISE_SLOW, EN_RISE_FAST), umax(EN_FALL, EN_FALL_SW));
  localparam int unsigned MAX_T = umax(umax(MAX_A, MAX_B), PB_INT_DEGL);
  localparam int unsigned CW    = $clog2(MAX_T + 1);

  logic pin_s, tick;
  logic lvl_q, int_exp;
  logic main_run, main_exp;
  logic [CW-1:0] main_lim;
  pb_state_e st_q, st_d;
  logic en_lvl_q, sw_flag_q, pwr_q;
  logic on_d, off_d, on_q, off_q;

  pr_sync2 #(.W(1)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (btn_pin_i), .q_o (pin_s)
  );

  pr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  // Interrupt-level filter: both edges, same qualification length
  pr_hold_timer #(.CW(CW)) u_int_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
    .run_i (pin_s ^ lvl_q), .limit_i (CW'(PB_INT_DEGL)), .expire_o (int_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= 1'b1;
    else if (int_exp) lvl_q <= pin_s;
  end

  // Shared qualification timer for ON/OFF decisions
  always_comb begin
    main_run = 1'b0;
    main_lim = CW'(PB_REL_DEGL);
    if (pb_mode_i) begin
      case (st_q)
        PB_HOLD: begin
          main_run = ~pin_s;
          main_lim = power_on_i ? CW'(PB_OFF_HOLD)
                   : (fast_i ? CW'(PB_ON_FAST) : CW'(PB_ON_SLOW));
        end
        PB_REL: begin
          main_run = pin_s;
          main_lim = CW'(PB_REL_DEGL);
        end
        default: main_run = 1'b0;
      endcase
    end else begin
      main_run = pin_s ^ en_lvl_q;
      if (en_lvl_q) main_lim = sw_flag_q ? CW'(EN_FALL_SW) : CW'(EN_FALL);
      else          main_lim = fast_i ? CW'(EN_RISE_FAST) : CW'(EN_RISE_SLOW);
    end
  end

  pr_hold_timer #(.CW(CW)) u_main_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
    .run_i (main_run), .limit_i (main_lim), .expire_o (main_exp)
  );

  // Push-button sequence
  always_comb begin
    st_d = st_q;
    case (st_q)
      PB_IDLE: if (!pin_s) st_d = PB_HOLD;
      PB_HOLD: begin
        if (pin_s)         st_d = PB_IDLE;
        else if (main_exp) st_d = power_on_i ? PB_REL : PB_WAIT;
      end
      PB_WAIT: if (pin_s)    st_d = PB_IDLE;
      PB_REL:  if (main_exp) st_d = PB_IDLE;
      default: st_d = PB_IDLE;
    endcase
    if (!pb_mode_i) st_d = PB_IDLE;
  end

  always_comb begin
    if (pb_mode_i) begin
      on_d  = main_exp && (st_q == PB_HOLD) && !power_on_i;
      off_d = main_exp && (st_q == PB_HOLD) &&  power_on_i;
    end else begin
      on_d  = main_exp && !en_lvl_q && !power_on_i;
      off_d = main_exp &&  en_lvl_q &&  power_on_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= PB_IDLE;
      en_lvl_q  <= 1'b0;
      sw_flag_q <= 1'b0;
      pwr_q     <= 1'b0;
      on_q      <= 1'b0;
      off_q     <= 1'b0;
    end else begin
      st_q  <= st_d;
      pwr_q <= power_on_i;
      on_q  <= on_d;
      off_q <= off_d;
      if (!pb_mode_i && main_exp) en_lvl_q <= pin_s;
      if (sw_shdn_i)                               sw_flag_q <= 1'b1;
      else if (power_on_i && !pwr_q)               sw_flag_q <= 1'b0;
      else if (!pb_mode_i && main_exp && en_lvl_q) sw_flag_q <= 1'b0;
    end
  end

  assign on_req_o    = on_q;
  assign off_req_o   = off_q;
  assign btn_level_o = lvl_q;

  // R11
  on_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q |=> !on_q);
  // R11
  off_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |=> !off_q);
  // R11
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on_q && off_q));
  // R10
  on_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q |-> !$past(power_on_i));
  // R10
  off_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> $past(power_on_i));
  // R4
  rel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PB_REL) |=> (st_q == PB_REL || st_q == PB_IDLE));

endmodule

// File: tb/test_pwr_req_ctrl.sv
module test_pwr_req_ctrl;
  localparam int D    = 4;
  localparam int ONS  = 30;
  localparam int ONF  = 10;
  localparam int OFFH = 60;
  localparam int REL  = 20;
  localparam int INTD = 8;
  localparam int ERS  = 25;
  localparam int ERF  = 6;
  localparam int EF   = 12;
  localparam int EFS  = 4;

  typedef struct {
    bit    kind;   // 0 = ON, 1 = OFF
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, pbm = 1'b1, fst = 1'b0, sws = 1'b0, pwr = 1'b0;
  logic on_req, off_req, lvl;
  int   cyc = 0, checks = 0, errors = 0, unexp = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  pwr_req_ctrl #(
    .TICK_DIV(D), .PB_ON_SLOW(ONS), .PB_ON_FAST(ONF), .PB_OFF_HOLD(OFFH),
    .PB_REL_DEGL(REL), .PB_INT_DEGL(INTD), .EN_RISE_SLOW(ERS),
    .EN_RISE_FAST(ERF), .EN_FALL(EF), .EN_FALL_SW(EFS)
  ) i_pwr_req_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .btn_pin_i(pin), .pb_mode_i(pbm),
    .fast_i(fst), .sw_shdn_i(sws), .power_on_i(pwr),
    .on_req_o(on_req), .off_req_o(off_req), .btn_level_o(lvl)
  );

  // Monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    if (rst_n && (on_req || off_req)) begin
      checks++;
      if (q.size() == 0) begin
        errors++; unexp++;
        $display("FAIL R10/R11 unexpected pulse at %0d: on=%0b off=%0b, expected none",
                 cyc, on_req, off_req);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.kind != off_req || on_req == off_req || cyc < e.lo || cyc > e.hi) begin
          errors++;
          $display("FAIL %s: kind off=%0b at cycle %0d, expected off=%0b in [%0d,%0d]",
                   e.tag, off_req, cyc, e.kind, e.lo, e.hi);
        end
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    pin = v;
  endtask

  task automatic set_pwr(input logic v);
    @(negedge clk);
    pwr = v;
  endtask

  task automatic expect_req(input bit kind, input int lim, input string tag);
    exp_t e;
    e.kind = kind;
    e.lo   = cyc + (lim - 1) * D + 3;
    e.hi   = cyc + lim * D + 3;
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic drain(input string tag);
    hold(4);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d request(s) missing, expected 0", tag, q.size());
      q.delete();
    end
  endtask

  task automatic quiet(input int n, input string tag);
    int u0;
    u0 = unexp;
    hold(n);
    checks++;
    if (unexp != u0) begin
      errors++;
      $display("FAIL %s: %0d unexpected pulse(s), expected 0", tag, unexp - u0);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic pb, input logic f, input logic p);
    @(negedge clk);
    rst_n = 1'b0; pbm = pb; fst = f; pin = p; pwr = 1'b0; sws = 1'b0;
    hold(3);
    rst_n = 1'b1;
  endtask

  task automatic sw_pulse();
    @(negedge clk); sws = 1'b1;
    @(negedge clk); sws = 1'b0;
  endtask

  initial begin
    // ---------------- push-button, slow ----------------
    do_reset(1'b1, 1'b0, 1'b1);
    check_bit(on_req, 1'b0, "R1 on_req after reset");
    check_bit(off_req, 1'b0, "R1 off_req after reset");
    check_bit(lvl, 1'b1, "R1 btn_level after reset");

    drive(1'b0);
    expect_req(1'b0, ONS, "R2 slow ON press");
    hold((INTD - 1) * D + 2);
    check_bit(lvl, 1'b1, "R6 level before fall qualifies");
    hold(D + 1);
    check_bit(lvl, 1'b0, "R6 level after fall qualifies");
    hold(ONS * D);
    set_pwr(1'b1);
    drive(1'b1);
    hold((INTD - 1) * D + 2);
    check_bit(lvl, 1'b0, "R6 level before rise qualifies");
    hold(D + 1);
    check_bit(lvl, 1'b1, "R6 level after rise qualifies");
    drain("R2 slow ON press");

    // R5: bounces shorter than the OFF hold
    drive(1'b0); hold(20);
    drive(1'b1); hold(5);
    drive(1'b0); hold(20);
    drive(1'b1);
    quiet(100, "R5 push-button bounce");

    // R3: long press while on
    drive(1'b0);
    expect_req(1'b1, OFFH, "R3 long-press OFF");
    hold(OFFH * D + 10);
    set_pwr(1'b0);
    drain("R3 long-press OFF");

    // R4: release not yet qualified, then a long low gives nothing
    drive(1'b1); hold((REL / 2) * D);
    drive(1'b0);
    quiet((ONS + 10) * D, "R4 press before release qualified");
    drive(1'b1); hold((REL + 3) * D);
    drive(1'b0);
    expect_req(1'b0, ONS, "R4 press after release qualified");
    hold(ONS * D + 10);
    drive(1'b1);
    drain("R4 press after release qualified");

    // ---------------- push-button, fast ----------------
    do_reset(1'b1, 1'b1, 1'b1);
    hold(4);
    drive(1'b0);
    expect_req(1'b0, ONF, "R2 fast ON press");
    hold((OFFH + 5) * D);
    drive(1'b1);
    drain("R2 fast ON press, single pulse while held");

    // ---------------- enable, slow ----------------
    do_reset(1'b0, 1'b0, 1'b0);
    hold(4);
    drive(1'b1);
    expect_req(1'b0, ERS, "R7 enable rise slow");
    hold(ERS * D + 6);
    set_pwr(1'b1);
    drain("R7 enable rise slow");

    drive(1'b0); hold(2 * D);
    drive(1'b1);
    quiet(EF * D * 2, "R5 enable fall bounce");

    drive(1'b0);
    expect_req(1'b1, EF, "R8 enable fall");
    hold(EF * D + 6);
    set_pwr(1'b0);
    drain("R8 enable fall");

    set_pwr(1'b1);
    drive(1'b1);
    quiet((ERS + 5) * D, "R10 rise while powered on");
    set_pwr(1'b0);
    drive(1'b0);
    quiet((EF + 5) * D, "R10 fall while powered off");

    // ---------------- enable, fast ----------------
    do_reset(1'b0, 1'b1, 1'b0);
    hold(4);
    drive(1'b1);
    expect_req(1'b0, ERF, "R7 enable rise fast");
    hold(ERF * D + 6);
    set_pwr(1'b1);
    drain("R7 enable rise fast");

    sw_pulse();
    drive(1'b0);
    expect_req(1'b1, EFS, "R9 short fall after software shutdown");
    hold(EFS * D + 6);
    set_pwr(1'b0);
    drain("R9 short fall after software shutdown");

    drive(1'b1);
    expect_req(1'b0, ERF, "R9 rise after short fall");
    hold(ERF * D + 6);
    set_pwr(1'b1);
    drain("R9 rise after short fall");
    drive(1'b0);
    expect_req(1'b1, EF, "R9 flag cleared after use");
    hold(EF * D + 6);
    set_pwr(1'b0);
    drain("R9 flag cleared after use");

    drive(1'b1);
    expect_req(1'b0, ERF, "R9 rise before power-on clear");
    hold(ERF * D + 6);
    set_pwr(1'b1);
    drain("R9 rise before power-on clear");
    sw_pulse();
    set_pwr(1'b0); hold(3);
    set_pwr(1'b1); hold(3);
    drive(1'b0);
    expect_req(1'b1, EF, "R9 flag cleared by power-on");
    hold(EF * D + 6);
    set_pwr(1'b0);
    drain("R9 flag cleared by power-on");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule